// File: doc/BRIEF.md
# Register-Pair Unsigned Divider

This block is a sequential unsigned divider that works on values held in four half-width register pairs, named here AX, BC, DE and HL. In narrow mode it divides AX by DE and returns the quotient in AX and the remainder in DE. In wide mode it joins two halves into each operand: BC:AX is the dividend and HL:DE is the divisor, with BC and HL as the upper halves. The quotient goes back to BC:AX and the remainder to HL:DE.

An operation starts when `start_i` is pulsed while the unit is idle. `wide_i` selects the mode and the operand inputs are sampled on that same edge. The unit uses a restoring shift-subtract algorithm that settles `RADIX_BITS` quotient bits per clock. Each mode therefore has a fixed latency: 9 clocks for narrow and 17 for wide with the default parameters. A zero divisor does not raise a trap. It follows the natural outcome of the restoring algorithm: an all-ones quotient, with the dividend returned as the remainder.

Top module: `pairdiv_unit`

## Requirements
- R1: Narrow mode (`wide_i`=0 at the accepted start): `ax_o` = floor(AX/DE) and `de_o` = AX mod DE, both operands unsigned, for any nonzero DE.
- R2: Wide mode (`wide_i`=1): {`bc_o`,`ax_o`} = floor({BC,AX}/{HL,DE}) and {`hl_o`,`de_o`} = the unsigned remainder, with BC and HL as the upper halves, for any nonzero divisor.
- R3: With a zero divisor in either mode, every quotient bit of that mode is one and the remainder equals the dividend.
- R4: In narrow mode, `bc_i` and `hl_i` have no effect on the quotient or remainder. On completion `bc_o` and `hl_o` equal the `bc_i` and `hl_i` values sampled at the accepted start.
- R5: In narrow mode, `done_o` is first high exactly HALF_W/RADIX_BITS+1 rising edges after the edge that accepts `start_i` (9 by default).
- R6: In wide mode, `done_o` is first high exactly 2*HALF_W/RADIX_BITS+1 rising edges after the accepting edge (17 by default).
- R7: `busy_o` is high from the accepting edge until the completing edge. `done_o` stays high for exactly one cycle and is never high together with `busy_o`.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. The running operation keeps its operands and its latency, and no extra completion follows.
- R9: `ax_o`, `bc_o`, `de_o` and `hl_o` change only in the cycle in which `done_o` rises, and they hold their values between completions.
- R10: While `rst_n` is low, all result outputs are zero and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts an operation when the unit is idle |
| wide_i | input | 1 | 1 selects wide mode, 0 selects narrow mode |
| ax_i | input | HALF_W | AX: lower dividend half (the whole dividend in narrow mode) |
| bc_i | input | HALF_W | BC: upper dividend half in wide mode |
| de_i | input | HALF_W | DE: lower divisor half (the whole divisor in narrow mode) |
| hl_i | input | HALF_W | HL: upper divisor half in wide mode |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion strobe |
| ax_o | output | HALF_W | Quotient, lower half |
| bc_o | output | HALF_W | Quotient, upper half (wide mode) or BC passed through (narrow mode) |
| de_o | output | HALF_W | Remainder, lower half |
| hl_o | output | HALF_W | Remainder, upper half (wide mode) or HL passed through (narrow mode) |

## Verification
The bench builds the unit with HALF_W=4 and RADIX_BITS=2. This shrinks the narrow operation to a 4-bit by 4-bit division that completes in 3 clocks, and the wide operation to an 8-bit by 8-bit division that completes in 5 clocks. At that size every narrow dividend and divisor pair can be tried, including every zero-divisor case. Every 8-bit wide dividend is paired with a spread of divisors that covers zero, one, powers of two and the values at either edge of the half boundary. The small latencies also make it cheap to check the exact completion edge for every operation, and to inject a start in the middle of a run.

// File: rtl/pairdiv_pkg.sv
package pairdiv_pkg;

  // Sequencer states of the divider.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

endpackage

// File: rtl/pairdiv_operands.sv
// Builds the working dividend and divisor from the register halves.
// In narrow mode the dividend is placed at the top of the shift register,
// so that HALF_W steps move it completely into the partial remainder.
module pairdiv_operands #(
  parameter int HALF_W = 16
) (
  input  logic                  wide_i,
  input  logic [HALF_W-1:0]     ax_i,
  input  logic [HALF_W-1:0]     bc_i,
  input  logic [HALF_W-1:0]     de_i,
  input  logic [HALF_W-1:0]     hl_i,
  output logic [2*HALF_W-1:0]   dividend_o,
  output logic [2*HALF_W-1:0]   divisor_o
);
  localparam int W = 2 * HALF_W;

  always_comb begin
    if (wide_i) begin
      dividend_o = {bc_i, ax_i};
      divisor_o  = {hl_i, de_i};
    end else begin
      dividend_o = {ax_i, {HALF_W{1'b0}}};
      divisor_o  = W'(de_i);
    end
  end
endmodule

// File: rtl/pairdiv_step.sv
// One clock's worth of restoring division: RB shift-compare-subtract
// stages chained together combinationally.
module pairdiv_step #(
  parameter int W  = 32,
  parameter int RB = 2
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dsr_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  always_comb begin
    logic [W:0]   sh;
    logic [W:0]   df;
    logic [W-1:0] r;
    logic [W-1:0] q;
    logic         ge;
    r = rem_i;
    q = quo_i;
    for (int k = 0; k < RB; k++) begin
      sh = {r, q[W-1]};
      ge = (sh >= {1'b0, dsr_i});
      df = sh - {1'b0, dsr_i};
      q  = {q[W-2:0], ge};
      r  = ge ? df[W-1:0] : sh[W-1:0];
    end
    rem_o = r;
    quo_o = q;
  end
endmodule

// File: rtl/pairdiv_ctrl.sv
// Sequencer: accepts a start while idle, counts iterations, then finishes.
module pairdiv_ctrl
  import pairdiv_pkg::*;
#(
  parameter int NARROW_ITERS = 8,
  parameter int WIDE_ITERS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic wide_i,
  output logic load_o,
  output logic step_o,
  output logic finish_o,
  output logic busy_o,
  output logic wide_q_o
);
  localparam int CNT_W = $clog2(WIDE_ITERS + 1);

  div_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             wide_q, wide_n;

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    wide_n   = wide_q;
    load_o   = 1'b0;
    step_o   = 1'b0;
    finish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          wide_n  = wide_i;
          cnt_n   = wide_i ? CNT_W'(WIDE_ITERS - 1) : CNT_W'(NARROW_ITERS - 1);
          state_n = ST_RUN;
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        if (cnt_q == '0) state_n = ST_FIN;
        else             cnt_n   = cnt_q - 1'b1;
      end
      ST_FIN: begin
        finish_o = 1'b1;
        state_n  = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wide_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      wide_q  <= wide_n;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign wide_q_o = wide_q;
endmodule

// File: rtl/pairdiv_unit.sv
// Register-pair unsigned divider, narrow (HALF_W) and wide (2*HALF_W) modes.
module pairdiv_unit #(
  parameter int HALF_W     = 16,
  parameter int RADIX_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              wide_i,
  input  logic [HALF_W-1:0] ax_i,
  input  logic [HALF_W-1:0] bc_i,
  input  logic [HALF_W-1:0] de_i,
  input  logic [HALF_W-1:0] hl_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [HALF_W-1:0] ax_o,
  output logic [HALF_W-1:0] bc_o,
  output logic [HALF_W-1:0] de_o,
  output logic [HALF_W-1:0] hl_o
);
  localparam int W            = 2 * HALF_W;
  localparam int NARROW_ITERS = HALF_W / RADIX_BITS;
  localparam int WIDE_ITERS   = W / RADIX_BITS;

  logic         load, step, finish, busy, wide_q;
  logic [W-1:0] dividend, divisor;
  logic [W-1:0] rem_q, rem_n, quo_q, quo_n, dsr_q, dsr_n;
  logic [W-1:0] rem_step, quo_step;
  logic [HALF_W-1:0] bck_q, bck_n, hlk_q, hlk_n;
  logic [HALF_W-1:0] ax_q, ax_n, bc_q, bc_n, de_q, de_n, hl_q, hl_n;
  logic         done_q, done_n;

  pairdiv_ctrl #(
    .NARROW_ITERS (NARROW_ITERS),
    .WIDE_ITERS   (WIDE_ITERS)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .wide_i   (wide_i),
    .load_o   (load),
    .step_o   (step),
    .finish_o (finish),
    .busy_o   (busy),
    .wide_q_o (wide_q)
  );

  pairdiv_operands #(.HALF_W(HALF_W)) u_ops (
    .wide_i     (wide_i),
    .ax_i       (ax_i),
    .bc_i       (bc_i),
    .de_i       (de_i),
    .hl_i       (hl_i),
    .dividend_o (dividend),
    .divisor_o  (divisor)
  );

  pairdiv_step #(.W(W), .RB(RADIX_BITS)) u_step (
    .rem_i (rem_q),
    .quo_i (quo_q),
    .dsr_i (dsr_q),
    .rem_o (rem_step),
    .quo_o (quo_step)
  );

  // Next-state logic of the datapath and result registers.
  always_comb begin
    rem_n  = rem_q;
    quo_n  = quo_q;
    dsr_n  = dsr_q;
    bck_n  = bck_q;
    hlk_n  = hlk_q;
    ax_n   = ax_q;
    bc_n   = bc_q;
    de_n   = de_q;
    hl_n   = hl_q;
    done_n = 1'b0;
    if (load) begin
      rem_n = '0;
      quo_n = dividend;
      dsr_n = divisor;
      bck_n = bc_i;
      hlk_n = hl_i;
    end else if (step) begin
      rem_n = rem_step;
      quo_n = quo_step;
    end
    if (finish) begin
      ax_n   = quo_q[HALF_W-1:0];
      de_n   = rem_q[HALF_W-1:0];
      done_n = 1'b1;
      if (wide_q) begin
        bc_n = quo_q[W-1:HALF_W];
        hl_n = rem_q[W-1:HALF_W];
      end else begin
        bc_n = bck_q;
        hl_n = hlk_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dsr_q  <= '0;
      bck_q  <= '0;
      hlk_q  <= '0;
      ax_q   <= '0;
      bc_q   <= '0;
      de_q   <= '0;
      hl_q   <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      dsr_q  <= dsr_n;
      bck_q  <= bck_n;
      hlk_q  <= hlk_n;
      ax_q   <= ax_n;
      bc_q   <= bc_n;
      de_q   <= de_n;
      hl_q   <= hl_n;
      done_q <= done_n;
    end
  end

  assign busy_o = busy;
  assign done_o = done_q;
  assign ax_o   = ax_q;
  assign bc_o   = bc_q;
  assign de_o   = de_q;
  assign hl_o   = hl_q;
endmodule

// File: rtl/pairdiv_unit_chk.sv
// Port-level checker for pairdiv_unit, attached through bind below.
module pairdiv_unit_chk #(
  parameter int HALF_W     = 16,
  parameter int RADIX_BITS = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              wide_i,
  input logic [HALF_W-1:0] ax_i,
  input logic [HALF_W-1:0] bc_i,
  input logic [HALF_W-1:0] de_i,
  input logic [HALF_W-1:0] hl_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [HALF_W-1:0] ax_o,
  input logic [HALF_W-1:0] bc_o,
  input logic [HALF_W-1:0] de_o,
  input logic [HALF_W-1:0] hl_o
);
  localparam int NARROW_LAT = HALF_W / RADIX_BITS + 1;
  localparam int WIDE_LAT   = 2 * HALF_W / RADIX_BITS + 1;

  logic              acc;
  logic              wide_l;
  logic [HALF_W-1:0] ax_l, bc_l, de_l, hl_l;
  logic [15:0]       cnt;

  assign acc = start_i && !busy_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_l <= 1'b0;
      ax_l   <= '0;
      bc_l   <= '0;
      de_l   <= '0;
      hl_l   <= '0;
      cnt    <= '0;
    end else if (acc) begin
      wide_l <= wide_i;
      ax_l   <= ax_i;
      bc_l   <= bc_i;
      de_l   <= de_i;
      hl_l   <= hl_i;
      cnt    <= '0;
    end else if (busy_o) begin
      cnt    <= cnt + 16'd1;
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy_o);

  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !wide_l) |-> (cnt == 16'(NARROW_LAT)));

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && wide_l) |-> (cnt == 16'(WIDE_LAT)));

  p_zero_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !wide_l && de_l == '0) |-> (ax_o == '1 && de_o == ax_l));

  p_zero_wide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && wide_l && de_l == '0 && hl_l == '0)
      |-> (ax_o == '1 && bc_o == '1 && de_o == ax_l && hl_o == bc_l));

  p_keep_pairs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !wide_l) |-> (bc_o == bc_l && hl_o == hl_l));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(ax_o) && $stable(bc_o) && $stable(de_o) && $stable(hl_o)));
endmodule

bind pairdiv_unit pairdiv_unit_chk #(
  .HALF_W     (HALF_W),
  .RADIX_BITS (RADIX_BITS)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .wide_i  (wide_i),
  .ax_i    (ax_i),
  .bc_i    (bc_i),
  .de_i    (de_i),
  .hl_i    (hl_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ax_o    (ax_o),
  .bc_o    (bc_o),
  .de_o    (de_o),
  .hl_o    (hl_o)
);

// File: tb/sim_pairdiv_unit.sv
module sim_pairdiv_unit;
  localparam int HW = 4;
  localparam int RB = 2;
  localparam int W  = 2 * HW;
  localparam int NL = HW / RB + 1;
  localparam int WL = W / RB + 1;

  logic          clk, rst_n, start_i, wide_i;
  logic [HW-1:0] ax_i, bc_i, de_i, hl_i;
  logic          busy_o, done_o;
  logic [HW-1:0] ax_o, bc_o, de_o, hl_o;

  int checks   = 0;
  int failures = 0;

  pairdiv_unit #(.HALF_W(HW), .RADIX_BITS(RB)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
    .ax_i(ax_i), .bc_i(bc_i), .de_i(de_i), .hl_i(hl_i),
    .busy_o(busy_o), .done_o(done_o),
    .ax_o(ax_o), .bc_o(bc_o), .de_o(de_o), .hl_o(hl_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Issues one operation and returns the number of edges to completion.
  task automatic run_op(input bit wide, input logic [HW-1:0] a, b, d, h,
                        output int lat);
    @(negedge clk);
    wide_i = wide; ax_i = a; bc_i = b; de_i = d; hl_i = h; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R7", "busy after accept", 32'(busy_o), 32'd1);
    lat = 0;
    while (!done_o && lat < 64) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic check_result(input bit wide, input logic [HW-1:0] a, b, d, h);
    logic [W-1:0] dv, ds, q, r;
    string req;
    if (wide) begin
      dv = {b, a}; ds = {h, d};
      q = (ds == 0) ? '1 : dv / ds;
      r = (ds == 0) ? dv : dv % ds;
      req = (ds == 0) ? "R3" : "R2";
      chk({bc_o, ax_o} == q, req, "wide quotient", 32'({bc_o, ax_o}), 32'(q));
      chk({hl_o, de_o} == r, req, "wide remainder", 32'({hl_o, de_o}), 32'(r));
    end else begin
      q = (d == 0) ? W'({HW{1'b1}}) : W'(a / d);
      r = (d == 0) ? W'(a) : W'(a % d);
      req = (d == 0) ? "R3" : "R1";
      chk(ax_o == q[HW-1:0], req, "narrow quotient", 32'(ax_o), 32'(q[HW-1:0]));
      chk(de_o == r[HW-1:0], req, "narrow remainder", 32'(de_o), 32'(r[HW-1:0]));
      chk(bc_o == b && hl_o == h, "R4", "pass-through pairs",
          32'({bc_o, hl_o}), 32'({b, h}));
    end
  endtask

  initial begin
    int lat;
    logic [W-1:0] dsr [18];
    logic [HW-1:0] sax, sbc, sde, shl;
    dsr = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd5, 8'd7, 8'd9, 8'd15, 8'd16,
            8'd17, 8'd31, 8'd64, 8'd100, 8'd127, 8'd128, 8'd200, 8'd254, 8'd255};
    rst_n = 1'b0; start_i = 1'b0; wide_i = 1'b0;
    ax_i = '0; bc_i = '0; de_i = '0; hl_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(!busy_o && !done_o, "R10", "busy/done in reset", 32'({busy_o, done_o}), 32'd0);
    chk({ax_o, bc_o, de_o, hl_o} == '0, "R10", "results in reset",
        32'({ax_o, bc_o, de_o, hl_o}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R3, R4, R5: exhaustive narrow sweep
    for (int a = 0; a < (1 << HW); a++) begin
      for (int d = 0; d < (1 << HW); d++) begin
        run_op(1'b0, HW'(a), HW'(a * 3 + 5), HW'(d), HW'(~d), lat);
        chk(lat == NL, "R5", "narrow latency", 32'(lat), 32'(NL));
        check_result(1'b0, HW'(a), HW'(a * 3 + 5), HW'(d), HW'(~d));
      end
    end

    // R2, R3, R6, R7: wide sweep over all dividends
    for (int v = 0; v < (1 << W); v++) begin
      for (int k = 0; k < 18; k++) begin
        run_op(1'b1, HW'(v), HW'(v >> HW), dsr[k][HW-1:0], dsr[k][W-1:HW], lat);
        chk(lat == WL, "R6", "wide latency", 32'(lat), 32'(WL));
        check_result(1'b1, HW'(v), HW'(v >> HW), dsr[k][HW-1:0], dsr[k][W-1:HW]);
        @(negedge clk);
        chk(done_o == 1'b0, "R7", "done one cycle", 32'(done_o), 32'd0);
      end
    end

    // R8: start while busy is ignored
    @(negedge clk);
    wide_i = 1'b1; ax_i = 4'hD; bc_i = 4'hB; de_i = 4'h7; hl_i = 4'h0; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    wide_i = 1'b0; ax_i = 4'h3; bc_i = 4'h1; de_i = 4'h0; hl_i = 4'h2; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 2;
    while (!done_o && lat < 64) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    chk(lat == WL, "R8", "latency with mid-run start", 32'(lat), 32'(WL));
    check_result(1'b1, 4'hD, 4'hB, 4'h7, 4'h0);
    begin
      int extra = 0;
      for (int i = 0; i < WL + 3; i++) begin
        @(negedge clk);
        if (done_o) extra++;
      end
      chk(extra == 0, "R8", "no extra completion", 32'(extra), 32'd0);
    end

    // R9: outputs hold between completions
    sax = ax_o; sbc = bc_o; sde = de_o; shl = hl_o;
    ax_i = 4'h9; bc_i = 4'h6; de_i = 4'h1; hl_i = 4'hF; wide_i = 1'b1;
    repeat (6) @(negedge clk);
    chk({ax_o, bc_o, de_o, hl_o} == {sax, sbc, sde, shl}, "R9", "hold outputs",
        32'({ax_o, bc_o, de_o, hl_o}), 32'({sax, sbc, sde, shl}));
    run_op(1'b0, 4'hE, 4'h0, 4'h4, 4'h0, lat);
    chk(busy_o == 1'b0, "R7", "idle at done", 32'(busy_o), 32'd0);
    check_result(1'b0, 4'hE, 4'h0, 4'h4, 4'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule